// File: doc/BRIEF.md
# Checksummed Recovery Write Receiver

This block sits behind the target-side bus layer of a recovery agent and turns the byte stream of one register write into either a register update or a protocol error. A frame is one command byte, a 16-bit payload length sent low byte first, the payload bytes, and a closing checksum byte. The block runs a CRC-8 over everything before the checksum. It compares the result with the closing byte, and only then decides what to do with the frame.

Every fault seen during the frame is only recorded as a flag until the checksum byte arrives or the frame ends early. At that point exactly one error class is chosen. A frame with an error leaves the target register alone and writes its code to the protocol-error output. Any bytes that follow are swallowed until the next stop or repeated start. Payload of the indirect-FIFO data command is not stored. It is packed into words and pushed to a FIFO port as it arrives, unless an error already known at that time blocks it. Each error class has its own one-cycle event pulse, which surrounding logic can feed into interrupt status bits and counters.

Top module: `rec_cmd_rx`

## Requirements
- R1: A frame whose checksum byte equals CRC-8 (polynomial x^8+x^2+x+1, initial 0x00, most significant bit first) over the command, length-low, length-high and payload bytes, and which has no other fault, pulses `reg_we` for one cycle in the cycle after the checksum byte is accepted. In that cycle `reg_sel` is the command, `reg_len` is the payload size, and `reg_wdata` holds payload byte k in bits 8k+7:8k, with unused bytes zero.
- R2: A checksum mismatch gives `proto_err`=4 with one `evt_crc` pulse in the cycle after the checksum byte, and no register write.
- R3: `in_par_err` set with either length byte or with the checksum byte is reported as a CRC error (code 4, `evt_crc`), even when the checksum matches.
- R4: A length field that differs from the size of the addressed register gives code 3 and `evt_len`. Sizes: 0x22 8 bytes, 0x24 4, 0x26 3, 0x28 3, 0x29 2, 0x2D 6.
- R5: A stop (`in_stop`) or repeated start (`in_restart`) that arrives after the command byte but before the checksum byte gives code 3 and `evt_len` in the following cycle, and no register write.
- R6: A command byte outside the set {0x22, 0x24, 0x26, 0x28, 0x29, 0x2D, 0x2F} gives code 1 and `evt_unsup`.
- R7: Commands 0x28, 0x2D and 0x2F are accepted only when `rec_mode` is high at the command byte. Otherwise they give code 1 and `evt_unsup`.
- R8: A write to a read-only register (0x22 or 0x29) gives code 1 and `evt_ro`, and no register write.
- R9: For command 0x2F the length must be a nonzero multiple of 4, otherwise code 3. Every four payload bytes form one `fifo_wdata` word, with the first byte in bits 7:0, pushed in the cycle after its last byte. This command never pulses `reg_we`.
- R10: If `fifo_full` is high when a word completes, that word and all later words of the frame are dropped. At the checksum byte the frame reports code 3 with `evt_fifo_ovf`.
- R11: After the checksum byte, input bytes are ignored until a stop or repeated start. Each new frame restarts the CRC and all fault flags.
- R12: When several faults coincide, the class chosen is CRC first, then unsupported, then read-only, then length, then FIFO overflow. Exactly one event pulses, together with `proto_err_we`. `proto_err` keeps the last error code and is not changed by error-free frames.
- R13: After reset, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | One received byte this cycle |
| in_data | input | 8 | Received byte |
| in_par_err | input | 1 | Bus parity error flag for this byte |
| in_stop | input | 1 | Stop seen on the bus |
| in_restart | input | 1 | Repeated start seen on the bus |
| rec_mode | input | 1 | Recovery mode active |
| fifo_full | input | 1 | Indirect FIFO cannot take a word |
| reg_we | output | 1 | Register commit strobe |
| reg_sel | output | 8 | Command code of the committed register |
| reg_wdata | output | MAX_BYTES*8 | Committed payload, little-endian |
| reg_len | output | LEN_W | Committed payload size in bytes |
| fifo_push | output | 1 | FIFO word push |
| fifo_wdata | output | WORD_BYTES*8 | FIFO word |
| proto_err | output | 8 | Last protocol error code |
| proto_err_we | output | 1 | Protocol error written this cycle |
| evt_crc | output | 1 | CRC-class error event |
| evt_len | output | 1 | Length error event |
| evt_unsup | output | 1 | Unsupported command event |
| evt_ro | output | 1 | Read-only write event |
| evt_fifo_ovf | output | 1 | FIFO overflow event |

## Verification
A CRC register that is not cleared between frames shows up as a CRC error on the next correct frame. This appears in the cycle after its checksum byte. A wrong remaining-byte count shifts where the checksum is expected, so a good frame is either rejected or reported as cut short within a byte or two. Errors in the fault flags or in the priority logic appear as the wrong `proto_err` code or the wrong event pulse in the decision cycle. Errors in the word packer appear as wrongly ordered bytes in `fifo_wdata`, or as a push that is missing or extra, one cycle after the fourth byte.

// File: rtl/rcr_pkg.sv
package rcr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEN_LO,
    ST_LEN_HI,
    ST_DATA,
    ST_PEC,
    ST_SKIP
  } rx_state_e;

  localparam logic [7:0] PERR_NONE  = 8'd0;
  localparam logic [7:0] PERR_UNSUP = 8'd1;
  localparam logic [7:0] PERR_LEN   = 8'd3;
  localparam logic [7:0] PERR_CRC   = 8'd4;

  localparam int EV_CRC   = 0;
  localparam int EV_LEN   = 1;
  localparam int EV_UNSUP = 2;
  localparam int EV_RO    = 3;
  localparam int EV_OVF   = 4;
  localparam int EV_NUM   = 5;

  localparam logic [7:0] CMD_FIFO_DATA = 8'h2F;

  typedef struct packed {
    logic       known;
    logic       read_only;
    logic       rec_only;
    logic       fifo;
    logic [7:0] size;
  } cmd_info_t;

  function automatic cmd_info_t cmd_lookup(input logic [7:0] code);
    cmd_info_t r;
    r = '0;
    case (code)
      8'h22: begin r.known = 1'b1; r.read_only = 1'b1; r.size = 8'd8; end
      8'h24: begin r.known = 1'b1; r.size = 8'd4; end
      8'h26: begin r.known = 1'b1; r.size = 8'd3; end
      8'h28: begin r.known = 1'b1; r.rec_only = 1'b1; r.size = 8'd3; end
      8'h29: begin r.known = 1'b1; r.read_only = 1'b1; r.size = 8'd2; end
      8'h2D: begin r.known = 1'b1; r.rec_only = 1'b1; r.size = 8'd6; end
      CMD_FIFO_DATA: begin r.known = 1'b1; r.rec_only = 1'b1; r.fifo = 1'b1; end
      default: r = '0;
    endcase
    return r;
  endfunction

  function automatic logic [7:0] crc8_step(input logic [7:0] crc_in, input logic [7:0] b);
    logic [7:0] c;
    logic       fb;
    c = crc_in;
    for (int i = 7; i >= 0; i--) begin
      fb = c[7] ^ b[i];
      c  = {c[6:0], 1'b0};
      if (fb) c = c ^ 8'h07;
    end
    return c;
  endfunction

endpackage

// File: rtl/rcr_crc8.sv
module rcr_crc8
  import rcr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       step,
  input  logic [7:0] din,
  output logic [7:0] crc
);

  logic [7:0] crc_q;
  logic [7:0] crc_d;

  always_comb begin
    crc_d = crc_q;
    if (start) begin
      crc_d = crc8_step(8'h00, din);
    end else if (step) begin
      crc_d = crc8_step(crc_q, din);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc_q <= '0;
    end else if (start || step) begin
      crc_q <= crc_d;
    end
  end

  assign crc = crc_q;

endmodule

// File: rtl/rcr_word_pack.sv
module rcr_word_pack #(
  parameter  int WORD_BYTES = 4,
  localparam int CNT_W      = $clog2(WORD_BYTES + 1),
  localparam int WORD_W     = WORD_BYTES * 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              byte_en,
  input  logic [7:0]        din,
  input  logic              fifo_full,
  output logic              push,
  output logic [WORD_W-1:0] word,
  output logic              ovf
);

  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [WORD_W-1:0] acc_q, acc_d;
  logic [WORD_W-1:0] filled;
  logic [WORD_W-1:0] word_q, word_d;
  logic              push_q, push_d;
  logic              last_byte;

  assign last_byte = byte_en && (cnt_q == CNT_W'(WORD_BYTES - 1));

  // byte lanes: lane g takes din when the count points at it
  for (genvar g = 0; g < WORD_BYTES; g++) begin : g_lane
    assign filled[g*8 +: 8] = (cnt_q == CNT_W'(g)) ? din : acc_q[g*8 +: 8];
  end

  always_comb begin
    cnt_d  = cnt_q;
    acc_d  = acc_q;
    word_d = word_q;
    push_d = 1'b0;
    if (clear) begin
      cnt_d = '0;
      acc_d = '0;
    end else if (byte_en) begin
      acc_d = filled;
      if (last_byte) begin
        cnt_d = '0;
        if (!fifo_full) begin
          push_d = 1'b1;
          word_d = filled;
        end
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      acc_q  <= '0;
      word_q <= '0;
      push_q <= 1'b0;
    end else begin
      push_q <= push_d;
      if (clear || byte_en) begin
        cnt_q <= cnt_d;
        acc_q <= acc_d;
      end
      if (push_d) begin
        word_q <= word_d;
      end
    end
  end

  assign ovf  = last_byte && fifo_full;
  assign push = push_q;
  assign word = word_q;

endmodule

// File: rtl/rcr_err_sel.sv
module rcr_err_sel
  import rcr_pkg::*;
(
  input  logic              crc_bad,
  input  logic              unsup,
  input  logic              ro,
  input  logic              len_bad,
  input  logic              ovf,
  output logic [7:0]        code,
  output logic [EV_NUM-1:0] evt
);

  always_comb begin
    code = PERR_NONE;
    evt  = '0;
    if (crc_bad) begin
      code        = PERR_CRC;
      evt[EV_CRC] = 1'b1;
    end else if (unsup) begin
      code          = PERR_UNSUP;
      evt[EV_UNSUP] = 1'b1;
    end else if (ro) begin
      code       = PERR_UNSUP;
      evt[EV_RO] = 1'b1;
    end else if (len_bad) begin
      code        = PERR_LEN;
      evt[EV_LEN] = 1'b1;
    end else if (ovf) begin
      code        = PERR_LEN;
      evt[EV_OVF] = 1'b1;
    end
  end

endmodule

// File: rtl/rec_cmd_rx.sv
module rec_cmd_rx
  import rcr_pkg::*;
#(
  parameter  int MAX_BYTES  = 8,
  parameter  int WORD_BYTES = 4,
  localparam int LEN_W      = $clog2(MAX_BYTES + 1),
  localparam int DATA_W     = MAX_BYTES * 8,
  localparam int WORD_W     = WORD_BYTES * 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [7:0]        in_data,
  input  logic              in_par_err,
  input  logic              in_stop,
  input  logic              in_restart,
  input  logic              rec_mode,
  input  logic              fifo_full,
  output logic              reg_we,
  output logic [7:0]        reg_sel,
  output logic [DATA_W-1:0] reg_wdata,
  output logic [LEN_W-1:0]  reg_len,
  output logic              fifo_push,
  output logic [WORD_W-1:0] fifo_wdata,
  output logic [7:0]        proto_err,
  output logic              proto_err_we,
  output logic              evt_crc,
  output logic              evt_len,
  output logic              evt_unsup,
  output logic              evt_ro,
  output logic              evt_fifo_ovf
);

  // frame state
  rx_state_e   state_q, state_d;
  logic [7:0]  cmd_q, cmd_d;
  cmd_info_t   info_q, info_d;
  logic [7:0]  len_lo_q, len_lo_d;
  logic [15:0] remain_q, remain_d;
  logic [15:0] got_q, got_d;
  logic        unsup_q, unsup_d;
  logic        ro_q, ro_d;
  logic        par_q, par_d;
  logic        lenbad_q, lenbad_d;
  logic        ovf_q, ovf_d;

  // output registers
  logic              reg_we_q, reg_we_d;
  logic [7:0]        reg_sel_q;
  logic [DATA_W-1:0] reg_wdata_q;
  logic [LEN_W-1:0]  reg_len_q;
  logic [7:0]        perr_q;
  logic              perr_we_q, perr_we_d;
  logic [EV_NUM-1:0] evt_q, evt_d;

  // combinational helpers
  logic              end_mark;
  logic              acc;
  logic              in_frame;
  logic              early_end;
  logic              pec_hit;
  logic              decide;
  logic              frame_start;
  cmd_info_t         info_now;
  logic [15:0]       full_len;
  logic              len_ok_now;
  logic [7:0]        crc_val;
  logic              crc_step;
  logic              pk_en;
  logic              pk_ovf;
  logic              lane_wr;
  logic              crc_bad;
  logic [7:0]        sel_code;
  logic [EV_NUM-1:0] sel_evt;
  logic              any_err;
  logic [7:0]        lane_q [MAX_BYTES];
  logic [DATA_W-1:0] lane_flat;

  assign end_mark    = in_stop | in_restart;
  assign acc         = in_valid & ~end_mark;
  assign in_frame    = (state_q == ST_LEN_LO) || (state_q == ST_LEN_HI) ||
                       (state_q == ST_DATA)   || (state_q == ST_PEC);
  assign early_end   = end_mark & in_frame;
  assign pec_hit     = acc & (state_q == ST_PEC);
  assign decide      = pec_hit | early_end;
  assign frame_start = acc & (state_q == ST_IDLE);
  assign info_now    = cmd_lookup(in_data);
  assign full_len    = {in_data, len_lo_q};
  assign len_ok_now  = info_q.fifo
                       ? ((full_len != 16'd0) && ((full_len % 16'(WORD_BYTES)) == 16'd0))
                       : (full_len == {8'h00, info_q.size});
  assign crc_step    = acc & ((state_q == ST_LEN_LO) || (state_q == ST_LEN_HI) ||
                              (state_q == ST_DATA));
  assign pk_en       = acc & (state_q == ST_DATA) & info_q.fifo &
                       ~unsup_q & ~ro_q & ~lenbad_q & ~ovf_q;
  assign lane_wr     = acc & (state_q == ST_DATA) & ~info_q.fifo;

  rcr_crc8 u_crc (
    .clk   (clk),
    .rst_n (rst_n),
    .start (frame_start),
    .step  (crc_step),
    .din   (in_data),
    .crc   (crc_val)
  );

  rcr_word_pack #(.WORD_BYTES(WORD_BYTES)) u_pack (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (frame_start),
    .byte_en   (pk_en),
    .din       (in_data),
    .fifo_full (fifo_full),
    .push      (fifo_push),
    .word      (fifo_wdata),
    .ovf       (pk_ovf)
  );

  assign crc_bad = par_q | (pec_hit & (in_par_err | (crc_val != in_data)));

  rcr_err_sel u_sel (
    .crc_bad (crc_bad),
    .unsup   (unsup_q),
    .ro      (ro_q),
    .len_bad (lenbad_q | early_end),
    .ovf     (ovf_q),
    .code    (sel_code),
    .evt     (sel_evt)
  );

  assign any_err = |sel_evt;

  // payload byte lanes for register commands
  for (genvar g = 0; g < MAX_BYTES; g++) begin : g_buf
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lane_q[g] <= '0;
      end else if (frame_start) begin
        lane_q[g] <= '0;
      end else if (lane_wr && (got_q == 16'(g))) begin
        lane_q[g] <= in_data;
      end
    end
    assign lane_flat[g*8 +: 8] = lane_q[g];
  end

  // next state
  always_comb begin
    state_d  = state_q;
    cmd_d    = cmd_q;
    info_d   = info_q;
    len_lo_d = len_lo_q;
    remain_d = remain_q;
    got_d    = got_q;
    unsup_d  = unsup_q;
    ro_d     = ro_q;
    par_d    = par_q;
    lenbad_d = lenbad_q;
    ovf_d    = ovf_q;
    case (state_q)
      ST_IDLE: begin
        if (acc) begin
          state_d  = ST_LEN_LO;
          cmd_d    = in_data;
          info_d   = info_now;
          unsup_d  = ~info_now.known | (info_now.rec_only & ~rec_mode);
          ro_d     = info_now.known & info_now.read_only;
          par_d    = 1'b0;
          lenbad_d = 1'b0;
          ovf_d    = 1'b0;
          got_d    = '0;
          remain_d = '0;
        end
      end
      ST_LEN_LO: begin
        if (early_end) begin
          state_d = ST_IDLE;
        end else if (acc) begin
          state_d  = ST_LEN_HI;
          len_lo_d = in_data;
          par_d    = par_q | in_par_err;
        end
      end
      ST_LEN_HI: begin
        if (early_end) begin
          state_d = ST_IDLE;
        end else if (acc) begin
          state_d  = (full_len == 16'd0) ? ST_PEC : ST_DATA;
          par_d    = par_q | in_par_err;
          lenbad_d = ~len_ok_now;
          remain_d = full_len;
        end
      end
      ST_DATA: begin
        if (early_end) begin
          state_d = ST_IDLE;
        end else if (acc) begin
          remain_d = remain_q - 16'd1;
          got_d    = got_q + 16'd1;
          ovf_d    = ovf_q | pk_ovf;
          if (remain_q == 16'd1) begin
            state_d = ST_PEC;
          end
        end
      end
      ST_PEC: begin
        if (early_end) begin
          state_d = ST_IDLE;
        end else if (acc) begin
          state_d = ST_SKIP;
        end
      end
      ST_SKIP: begin
        if (end_mark) begin
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // decision outputs
  always_comb begin
    reg_we_d  = decide & ~any_err & ~info_q.fifo;
    perr_we_d = decide & any_err;
    evt_d     = decide ? sel_evt : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      cmd_q    <= '0;
      info_q   <= '0;
      len_lo_q <= '0;
      remain_q <= '0;
      got_q    <= '0;
      unsup_q  <= 1'b0;
      ro_q     <= 1'b0;
      par_q    <= 1'b0;
      lenbad_q <= 1'b0;
      ovf_q    <= 1'b0;
    end else begin
      state_q  <= state_d;
      cmd_q    <= cmd_d;
      info_q   <= info_d;
      len_lo_q <= len_lo_d;
      remain_q <= remain_d;
      got_q    <= got_d;
      unsup_q  <= unsup_d;
      ro_q     <= ro_d;
      par_q    <= par_d;
      lenbad_q <= lenbad_d;
      ovf_q    <= ovf_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_we_q    <= 1'b0;
      reg_sel_q   <= '0;
      reg_wdata_q <= '0;
      reg_len_q   <= '0;
      perr_q      <= '0;
      perr_we_q   <= 1'b0;
      evt_q       <= '0;
    end else begin
      reg_we_q  <= reg_we_d;
      perr_we_q <= perr_we_d;
      evt_q     <= evt_d;
      if (reg_we_d) begin
        reg_sel_q   <= cmd_q;
        reg_wdata_q <= lane_flat;
        reg_len_q   <= LEN_W'(info_q.size);
      end
      if (perr_we_d) begin
        perr_q <= sel_code;
      end
    end
  end

  assign reg_we       = reg_we_q;
  assign reg_sel      = reg_sel_q;
  assign reg_wdata    = reg_wdata_q;
  assign reg_len      = reg_len_q;
  assign proto_err    = perr_q;
  assign proto_err_we = perr_we_q;
  assign evt_crc      = evt_q[EV_CRC];
  assign evt_len      = evt_q[EV_LEN];
  assign evt_unsup    = evt_q[EV_UNSUP];
  assign evt_ro       = evt_q[EV_RO];
  assign evt_fifo_ovf = evt_q[EV_OVF];

endmodule

// File: rtl/rcr_cmd_rx_chk.sv
module rcr_cmd_rx_chk #(
  parameter  int MAX_BYTES = 8,
  localparam int LEN_W     = $clog2(MAX_BYTES + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             fifo_full,
  input logic             reg_we,
  input logic [LEN_W-1:0] reg_len,
  input logic             fifo_push,
  input logic [7:0]       proto_err,
  input logic             proto_err_we,
  input logic             evt_crc,
  input logic             evt_len,
  input logic             evt_unsup,
  input logic             evt_ro,
  input logic             evt_fifo_ovf
);

  // R12
  evt_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({evt_crc, evt_len, evt_unsup, evt_ro, evt_fifo_ovf}));

  // R12
  perr_evt_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err_we == ($countones({evt_crc, evt_len, evt_unsup, evt_ro, evt_fifo_ovf}) == 1));

  // R12
  perr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !proto_err_we |-> (proto_err == $past(proto_err)));

  // R1
  commit_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> !proto_err_we);

  // R1
  commit_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> ((reg_len != '0) && (reg_len <= LEN_W'(MAX_BYTES))));

  // R10
  push_not_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_push |-> !$past(fifo_full));

  // R9
  push_no_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_push |-> !reg_we);

endmodule

bind rec_cmd_rx rcr_cmd_rx_chk #(.MAX_BYTES(MAX_BYTES)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .fifo_full    (fifo_full),
  .reg_we       (reg_we),
  .reg_len      (reg_len),
  .fifo_push    (fifo_push),
  .proto_err    (proto_err),
  .proto_err_we (proto_err_we),
  .evt_crc      (evt_crc),
  .evt_len      (evt_len),
  .evt_unsup    (evt_unsup),
  .evt_ro       (evt_ro),
  .evt_fifo_ovf (evt_fifo_ovf)
);

// File: tb/rec_cmd_rx_tb.sv
module rec_cmd_rx_tb;

  localparam int MAX_BYTES  = 8;
  localparam int WORD_BYTES = 4;
  localparam int LEN_W      = $clog2(MAX_BYTES + 1);

  logic                    clk;
  logic                    rst_n;
  logic                    in_valid;
  logic [7:0]              in_data;
  logic                    in_par_err;
  logic                    in_stop;
  logic                    in_restart;
  logic                    rec_mode;
  logic                    fifo_full;
  logic                    reg_we;
  logic [7:0]              reg_sel;
  logic [MAX_BYTES*8-1:0]  reg_wdata;
  logic [LEN_W-1:0]        reg_len;
  logic                    fifo_push;
  logic [WORD_BYTES*8-1:0] fifo_wdata;
  logic [7:0]              proto_err;
  logic                    proto_err_we;
  logic                    evt_crc, evt_len, evt_unsup, evt_ro, evt_fifo_ovf;

  rec_cmd_rx #(.MAX_BYTES(MAX_BYTES), .WORD_BYTES(WORD_BYTES)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_par_err(in_par_err), .in_stop(in_stop), .in_restart(in_restart),
    .rec_mode(rec_mode), .fifo_full(fifo_full), .reg_we(reg_we),
    .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_len(reg_len),
    .fifo_push(fifo_push), .fifo_wdata(fifo_wdata), .proto_err(proto_err),
    .proto_err_we(proto_err_we), .evt_crc(evt_crc), .evt_len(evt_len),
    .evt_unsup(evt_unsup), .evt_ro(evt_ro), .evt_fifo_ovf(evt_fifo_ovf)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int checks = 0;
  int failures = 0;
  logic done = 1'b0;

  // monitor
  int               n_we, n_push, n_perr;
  int               n_ecrc, n_elen, n_eunsup, n_ero, n_eovf;
  logic [7:0]       m_sel;
  logic [63:0]      m_data;
  logic [LEN_W-1:0] m_len;
  logic [31:0]      m_words [8];
  logic             we_at_pec, perr_at_pec, perr_at_end;

  always @(negedge clk) begin
    if (rst_n) begin
      if (reg_we) begin
        n_we++;
        m_sel  = reg_sel;
        m_data = reg_wdata;
        m_len  = reg_len;
      end
      if (fifo_push) begin
        if (n_push < 8) m_words[n_push] = fifo_wdata;
        n_push++;
      end
      if (proto_err_we) n_perr++;
      if (evt_crc) n_ecrc++;
      if (evt_len) n_elen++;
      if (evt_unsup) n_eunsup++;
      if (evt_ro) n_ero++;
      if (evt_fifo_ovf) n_eovf++;
    end
  end

  task automatic clr_mon();
    n_we = 0; n_push = 0; n_perr = 0;
    n_ecrc = 0; n_elen = 0; n_eunsup = 0; n_ero = 0; n_eovf = 0;
    m_sel = '0; m_data = '0; m_len = '0;
    we_at_pec = 1'b0; perr_at_pec = 1'b0; perr_at_end = 1'b0;
  endtask

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] crc_upd(input logic [7:0] c_in, input logic [7:0] b);
    logic [7:0] c;
    c = c_in;
    for (int i = 7; i >= 0; i--) begin
      if (c[7] ^ b[i]) c = {c[6:0], 1'b0} ^ 8'h07;
      else             c = {c[6:0], 1'b0};
    end
    return c;
  endfunction

  logic [7:0] pay [16];

  task automatic send_byte(input logic [7:0] b, input logic p);
    @(negedge clk);
    in_valid = 1'b1; in_data = b; in_par_err = p;
    @(negedge clk);
    in_valid = 1'b0; in_par_err = 1'b0;
  endtask

  task automatic send_end(input logic use_restart);
    @(negedge clk);
    if (use_restart) in_restart = 1'b1; else in_stop = 1'b1;
    @(negedge clk);
    in_stop = 1'b0; in_restart = 1'b0;
    perr_at_end = proto_err_we;
  endtask

  // n payload bytes from pay[]; cut>=0 ends the frame after that many payload bytes
  task automatic send_frame(input logic [7:0] cmd, input int n, input logic bad_crc,
                            input logic par_len, input logic par_pec, input int cut,
                            input int extra);
    logic [7:0] c;
    c = crc_upd(8'h00, cmd);
    send_byte(cmd, 1'b0);
    c = crc_upd(c, 8'(n));
    send_byte(8'(n), par_len);
    c = crc_upd(c, 8'(n >> 8));
    send_byte(8'(n >> 8), 1'b0);
    for (int i = 0; i < n; i++) begin
      if (cut == i) begin
        send_end(1'b1);
        repeat (3) @(negedge clk);
        return;
      end
      c = crc_upd(c, pay[i]);
      send_byte(pay[i], 1'b0);
    end
    send_byte(bad_crc ? ~c : c, par_pec);
    we_at_pec   = reg_we;
    perr_at_pec = proto_err_we;
    for (int i = 0; i < extra; i++) send_byte(8'h5A + 8'(i), 1'b0);
    send_end(1'b0);
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R13 reg_we", reg_we, 0);
    chk("R13 fifo_push", fifo_push, 0);
    chk("R13 proto_err", proto_err, 0);
    chk("R13 proto_err_we", proto_err_we, 0);
    chk("R13 events", {evt_crc, evt_len, evt_unsup, evt_ro, evt_fifo_ovf}, 0);
  endtask

  task automatic t_good();
    clr_mon();
    pay[0] = 8'h11; pay[1] = 8'h22; pay[2] = 8'h33; pay[3] = 8'h44;
    send_frame(8'h24, 4, 0, 0, 0, -1, 0);
    chk("R1 strobe after pec", we_at_pec, 1);
    chk("R1 count", n_we, 1);
    chk("R1 sel", m_sel, 8'h24);
    chk("R1 data", m_data, 64'h44332211);
    chk("R1 len", m_len, 4);
    chk("R1 no error", n_perr, 0);
    clr_mon();
    pay[0] = 8'hAA; pay[1] = 8'hBB; pay[2] = 8'hCC;
    send_frame(8'h26, 3, 0, 0, 0, -1, 0);
    chk("R11 second frame commits", n_we, 1);
    chk("R1 data zero padded", m_data, 64'h0000000000CCBBAA);
  endtask

  task automatic t_badcrc();
    clr_mon();
    send_frame(8'h24, 4, 1, 0, 0, -1, 0);
    chk("R2 no commit", n_we, 0);
    chk("R2 perr timing", perr_at_pec, 1);
    chk("R2 code", proto_err, 4);
    chk("R2 crc event", n_ecrc, 1);
  endtask

  task automatic t_parity();
    clr_mon();
    send_frame(8'h24, 4, 0, 1, 0, -1, 0);
    chk("R3 len parity code", proto_err, 4);
    chk("R3 len parity event", n_ecrc, 1);
    chk("R3 no commit", n_we, 0);
    clr_mon();
    send_frame(8'h24, 4, 0, 0, 1, -1, 0);
    chk("R3 pec parity event", n_ecrc, 1);
  endtask

  task automatic t_len();
    clr_mon();
    send_frame(8'h24, 3, 0, 0, 0, -1, 0);
    chk("R4 code", proto_err, 3);
    chk("R4 event", n_elen, 1);
    chk("R4 no commit", n_we, 0);
  endtask

  task automatic t_cut();
    clr_mon();
    send_frame(8'h24, 4, 0, 0, 0, 2, 0);
    chk("R5 timing", perr_at_end, 1);
    chk("R5 code", proto_err, 3);
    chk("R5 event", n_elen, 1);
    chk("R5 no commit", n_we, 0);
  endtask

  task automatic t_unknown();
    clr_mon();
    send_frame(8'h50, 2, 0, 0, 0, -1, 0);
    chk("R6 code", proto_err, 1);
    chk("R6 event", n_eunsup, 1);
  endtask

  task automatic t_recmode();
    clr_mon();
    rec_mode = 1'b0;
    send_frame(8'h28, 3, 0, 0, 0, -1, 0);
    chk("R7 blocked code", proto_err, 1);
    chk("R7 blocked event", n_eunsup, 1);
    chk("R7 blocked no commit", n_we, 0);
    clr_mon();
    rec_mode = 1'b1;
    pay[0] = 8'h01; pay[1] = 8'h02; pay[2] = 8'h03;
    send_frame(8'h28, 3, 0, 0, 0, -1, 0);
    chk("R7 allowed commit", n_we, 1);
    chk("R7 allowed sel", m_sel, 8'h28);
  endtask

  task automatic t_readonly();
    clr_mon();
    send_frame(8'h22, 8, 0, 0, 0, -1, 0);
    chk("R8 code", proto_err, 1);
    chk("R8 event", n_ero, 1);
    chk("R8 no commit", n_we, 0);
  endtask

  task automatic t_fifo();
    clr_mon();
    rec_mode = 1'b1;
    for (int i = 0; i < 8; i++) pay[i] = 8'(i + 1);
    send_frame(8'h2F, 8, 0, 0, 0, -1, 0);
    chk("R9 pushes", n_push, 2);
    chk("R9 word0", m_words[0], 32'h04030201);
    chk("R9 word1", m_words[1], 32'h08070605);
    chk("R9 no commit", n_we, 0);
    chk("R9 no error", n_perr, 0);
    clr_mon();
    send_frame(8'h2F, 6, 0, 0, 0, -1, 0);
    chk("R9 bad length pushes", n_push, 0);
    chk("R9 bad length code", proto_err, 3);
  endtask

  task automatic t_full();
    clr_mon();
    rec_mode = 1'b1;
    fifo_full = 1'b1;
    send_frame(8'h2F, 4, 0, 0, 0, -1, 0);
    fifo_full = 1'b0;
    chk("R10 no push", n_push, 0);
    chk("R10 event", n_eovf, 1);
    chk("R10 code", proto_err, 3);
  endtask

  task automatic t_drain();
    clr_mon();
    send_frame(8'h24, 4, 1, 0, 0, -1, 3);
    chk("R11 one error only", n_perr, 1);
    clr_mon();
    pay[0] = 8'h9A; pay[1] = 8'hBC; pay[2] = 8'hDE; pay[3] = 8'hF0;
    send_frame(8'h24, 4, 0, 0, 0, -1, 0);
    chk("R11 next frame commits", n_we, 1);
    chk("R11 next frame data", m_data, 64'hF0DEBC9A);
    chk("R12 code held after good frame", proto_err, 4);
  endtask

  task automatic t_prio();
    clr_mon();
    send_frame(8'h50, 2, 1, 0, 0, -1, 0);
    chk("R12 crc wins code", proto_err, 4);
    chk("R12 crc event", n_ecrc, 1);
    chk("R12 no unsup event", n_eunsup, 0);
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_data = '0; in_par_err = 1'b0;
    in_stop = 1'b0; in_restart = 1'b0; rec_mode = 1'b0; fifo_full = 1'b0;
    clr_mon();
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_good();
    t_badcrc();
    t_parity();
    t_len();
    t_cut();
    t_unknown();
    t_recmode();
    t_readonly();
    t_fifo();
    t_full();
    t_drain();
    t_prio();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule